// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer reached through three word registers on a simple register bus: a control/status word, a live counter, and a timeout limit. Software keeps the watchdog alive by writing a refresh key to the counter address. It must write an unlock key to that same address before the control word or the limit will accept any change. The unlock key can be given as one 32-bit word, or as two ordered 16-bit half-words when the wide-command bit is clear.

The counter advances on a low-rate tick enable that comes from outside the block. An optional divide-by-256 stage can slow it further. When the enabled count reaches the programmed limit, the block sets a sticky timeout flag and issues a one-cycle reset request. If the interrupt enable is set, the block raises a one-cycle interrupt first and issues the reset request a fixed number of bus clocks later.

Two status bits let software follow the protocol. One shows that the configuration window is open. The other shows that the last configuration write has been applied on the tick side.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset, the control word at offset 0x0 reads 0x0000_2420: wide-command bit 13 = 1, applied bit 10 = 1, update-allowed bit 5 = 1, all other bits 0. The counter at offset 0x4 reads 0. The limit at offset 0x8 reads LIMIT_RST (all ones by default). Offsets are word addresses on bus_addr.
- R2: With bit 13 set and bit 5 set, writing 0xD928C520 to offset 0x4 opens the configuration window, and bit 11 reads 1.
- R3: With bit 13 clear, the window opens only when a write of 0xC520 (low half) to offset 0x4 is directly followed by a write of 0xD928 to offset 0x4. The reverse order does not open it, and neither does any other counter-address write placed in between.
- R4: While the window is closed, writes to offsets 0x0 and 0x8 are ignored. Counter-address writes that are not a key are also ignored.
- R5: The window closes after ULK_WIN bus clocks, or right after one accepted write to offset 0x0 or 0x8, whichever comes first.
- R6: Writing 0xB480A602 to offset 0x4 (or 0xA602 then 0xB480 when bit 13 is clear) clears the counter to 0 on that clock, whether or not the window is open.
- R7: With enable bit 7 set, the counter advances once per tick. On the T-th advance after a refresh, where T is the limit, it sets flag bit 14, returns to 0 and asserts wdog_rst for one cycle. With bit 7 clear, the counter holds.
- R8: With prescaler bit 12 set, the counter advances once every 256 ticks, so expiry comes 256*T ticks after a refresh.
- R9: With interrupt-enable bit 6 set, expiry pulses wdog_irq for one cycle, and wdog_rst follows IRQ_LEAD clocks later. With bit 6 clear, wdog_irq stays low.
- R10: Applied bit 10 clears on each accepted configuration write and sets again on the next tick.
- R11: Bits 14, 11 and 10 ignore written values. Bits 4:2 and 31:15 read 0. Clock-select bits 9:8 and the run-in-wait (bit 1) and run-in-stop (bit 0) bits are stored as written.
- R12: Once update-allowed bit 5 is written 0, no unlock key is accepted until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Low-rate counting enable, one bus clock wide per tick |
| bus_we | input | 1 | Write strobe for bus_addr/bus_wdata |
| bus_addr | input | 4 | Word offset: 0x0 control, 0x4 counter/keys, 0x8 limit |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdog_irq | output | 1 | One-cycle early-warning pulse |
| wdog_rst | output | 1 | One-cycle reset request |

## Verification
The bench builds the block with a 16-bit counter, ULK_WIN = 16 and IRQ_LEAD = 3. With these values, the window close-by-time can be checked on the exact closing cycle, and the irq-to-reset spacing is short enough to count. Because the limit can be set to a small value, direct expiry can be measured on the exact tick. A limit of 2 with the prescaler keeps the divided expiry at 512 ticks, which still fits in a short run.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  localparam logic [3:0] OFS_CTRL  = 4'h0;
  localparam logic [3:0] OFS_COUNT = 4'h4;
  localparam logic [3:0] OFS_LIMIT = 4'h8;

  localparam logic [31:0] KEY_OPEN32 = 32'hD928_C520;
  localparam logic [31:0] KEY_FEED32 = 32'hB480_A602;
  localparam logic [15:0] KEY_OPEN_A = 16'hC520;
  localparam logic [15:0] KEY_OPEN_B = 16'hD928;
  localparam logic [15:0] KEY_FEED_A = 16'hA602;
  localparam logic [15:0] KEY_FEED_B = 16'hB480;

  localparam int B_FLAG = 14;
  localparam int B_WIDE = 13;
  localparam int B_PRES = 12;
  localparam int B_OPEN = 11;
  localparam int B_DONE = 10;
  localparam int B_CSEL = 8;
  localparam int B_EN   = 7;
  localparam int B_IRQ  = 6;
  localparam int B_UPD  = 5;
  localparam int B_WAIT = 1;
  localparam int B_STOP = 0;

  typedef struct packed {
    logic       wide;
    logic       pres;
    logic [1:0] csel;
    logic       en;
    logic       irq_en;
    logic       upd;
    logic       run_wait;
    logic       run_stop;
  } ctrl_t;
endpackage

// File: rtl/wdg_key_unit.sv
module wdg_key_unit
  import wdg_pkg::*;
#(
  parameter int WIN = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        key_wr,
  input  logic [31:0] key_data,
  input  logic        wide,
  input  logic        upd_ok,
  input  logic        cfg_wr,
  output logic        open_o,
  output logic        feed_o
);
  localparam int WW = $clog2(WIN + 1);

  logic          arm_open_q, arm_feed_q;
  logic          open_hit, feed_hit;
  logic [WW-1:0] win_q;

  always_comb begin
    if (wide) begin
      open_hit = (key_data == KEY_OPEN32);
      feed_hit = (key_data == KEY_FEED32);
    end else begin
      open_hit = arm_open_q && (key_data[15:0] == KEY_OPEN_B);
      feed_hit = arm_feed_q && (key_data[15:0] == KEY_FEED_B);
    end
  end

  assign feed_o = key_wr && feed_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_open_q <= 1'b0;
      arm_feed_q <= 1'b0;
    end else if (key_wr) begin
      arm_open_q <= !wide && (key_data[15:0] == KEY_OPEN_A);
      arm_feed_q <= !wide && (key_data[15:0] == KEY_FEED_A);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_o <= 1'b0;
      win_q  <= '0;
    end else if (cfg_wr) begin
      open_o <= 1'b0;
      win_q  <= '0;
    end else if (key_wr && open_hit && upd_ok) begin
      open_o <= 1'b1;
      win_q  <= WW'(WIN - 1);
    end else if (open_o) begin
      if (win_q == '0) open_o <= 1'b0;
      else             win_q  <= win_q - 1'b1;
    end
  end

  // R5: one accepted configuration write closes the window
  assert_close_on_cfg_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !open_o);
  // R12: no unlock while updates are disallowed
  assert_no_open_locked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_ok && !open_o) |=> !open_o);
endmodule

// File: rtl/wdg_count_unit.sv
module wdg_count_unit #(
  parameter int CW       = 16,
  parameter int PRE_BITS = 8,
  parameter int LEAD     = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          en,
  input  logic          pres,
  input  logic          irq_en,
  input  logic [CW-1:0] limit,
  input  logic          feed,
  output logic [CW-1:0] count_o,
  output logic          flag_o,
  output logic          irq_o,
  output logic          rst_o
);
  localparam int LW = $clog2(LEAD + 1);

  logic [PRE_BITS-1:0] div_q;
  logic [LW-1:0]       lead_q;
  logic                step, fire;
  logic [CW:0]         nxt;

  assign step = tick && en && (!pres || (&div_q));
  assign nxt  = {1'b0, count_o} + (CW+1)'(1);
  assign fire = step && !feed && (nxt >= {1'b0, limit});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_o <= '0;
      div_q   <= '0;
    end else if (feed) begin
      count_o <= '0;
      div_q   <= '0;
    end else begin
      if (tick && en && pres) div_q <= div_q + 1'b1;
      if (step) count_o <= fire ? '0 : nxt[CW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_o <= 1'b0;
      irq_o  <= 1'b0;
      rst_o  <= 1'b0;
      lead_q <= '0;
    end else begin
      if (fire) flag_o <= 1'b1;
      irq_o <= fire && irq_en;
      rst_o <= (fire && !irq_en) || (lead_q == LW'(1));
      if (fire && irq_en)   lead_q <= LW'(LEAD);
      else if (lead_q != '0) lead_q <= lead_q - 1'b1;
    end
  end

  // R6: a refresh leaves the counter at zero
  assert_feed_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    feed |=> (count_o == '0));
  // R7: a disabled counter holds its value
  assert_hold_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !feed) |=> $stable(count_o));
  // R7: a reset request is always accompanied by the sticky flag
  assert_rst_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> flag_o);
  // R7: the flag never clears once set
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flag_o |=> flag_o);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
  import wdg_pkg::*;
#(
  parameter int             CW        = 16,
  parameter int             ULK_WIN   = 128,
  parameter int             PRE_BITS  = 8,
  parameter int             IRQ_LEAD  = 4,
  parameter logic [CW-1:0]  LIMIT_RST = '1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        bus_we,
  input  logic [3:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        wdog_irq,
  output logic        wdog_rst
);
  ctrl_t         ctrl_q;
  logic [CW-1:0] limit_q;
  logic [CW-1:0] count;
  logic          open, feed, flag, done_q;
  logic          key_wr, ctrl_wr, limit_wr, cfg_wr;

  assign key_wr   = bus_we && (bus_addr == OFS_COUNT);
  assign ctrl_wr  = bus_we && (bus_addr == OFS_CTRL)  && open;
  assign limit_wr = bus_we && (bus_addr == OFS_LIMIT) && open;
  assign cfg_wr   = ctrl_wr || limit_wr;

  wdg_key_unit #(.WIN(ULK_WIN)) u_key (
    .clk      (clk),
    .rst_n    (rst_n),
    .key_wr   (key_wr),
    .key_data (bus_wdata),
    .wide     (ctrl_q.wide),
    .upd_ok   (ctrl_q.upd),
    .cfg_wr   (cfg_wr),
    .open_o   (open),
    .feed_o   (feed)
  );

  wdg_count_unit #(.CW(CW), .PRE_BITS(PRE_BITS), .LEAD(IRQ_LEAD)) u_count (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .en      (ctrl_q.en),
    .pres    (ctrl_q.pres),
    .irq_en  (ctrl_q.irq_en),
    .limit   (limit_q),
    .feed    (feed),
    .count_o (count),
    .flag_o  (flag),
    .irq_o   (wdog_irq),
    .rst_o   (wdog_rst)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '{wide: 1'b1, upd: 1'b1, default: '0};
      limit_q <= LIMIT_RST;
      done_q  <= 1'b1;
    end else begin
      if (ctrl_wr) begin
        ctrl_q.wide     <= bus_wdata[B_WIDE];
        ctrl_q.pres     <= bus_wdata[B_PRES];
        ctrl_q.csel     <= bus_wdata[B_CSEL+1:B_CSEL];
        ctrl_q.en       <= bus_wdata[B_EN];
        ctrl_q.irq_en   <= bus_wdata[B_IRQ];
        ctrl_q.upd      <= bus_wdata[B_UPD];
        ctrl_q.run_wait <= bus_wdata[B_WAIT];
        ctrl_q.run_stop <= bus_wdata[B_STOP];
      end
      if (limit_wr) limit_q <= bus_wdata[CW-1:0];
      if (cfg_wr)    done_q <= 1'b0;
      else if (tick) done_q <= 1'b1;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTRL: begin
        bus_rdata[B_FLAG]            = flag;
        bus_rdata[B_WIDE]            = ctrl_q.wide;
        bus_rdata[B_PRES]            = ctrl_q.pres;
        bus_rdata[B_OPEN]            = open;
        bus_rdata[B_DONE]            = done_q;
        bus_rdata[B_CSEL+1:B_CSEL]   = ctrl_q.csel;
        bus_rdata[B_EN]              = ctrl_q.en;
        bus_rdata[B_IRQ]             = ctrl_q.irq_en;
        bus_rdata[B_UPD]             = ctrl_q.upd;
        bus_rdata[B_WAIT]            = ctrl_q.run_wait;
        bus_rdata[B_STOP]            = ctrl_q.run_stop;
      end
      OFS_COUNT: bus_rdata = 32'(count);
      OFS_LIMIT: bus_rdata = 32'(limit_q);
      default:   bus_rdata = '0;
    endcase
  end

  // R4: limit is untouched by a write while the window is closed
  assert_locked_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == OFS_LIMIT) && !open) |=> $stable(limit_q));
  // R4: control word is untouched by a write while the window is closed
  assert_locked_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == OFS_CTRL) && !open) |=> $stable(ctrl_q));
  // R10: an accepted configuration write clears the applied bit
  assert_done_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> !done_q);
  // R10: a tick without configuration sets the applied bit
  assert_done_sets_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !cfg_wr) |=> done_q);
endmodule

// File: tb/keyed_watchdog_bench.sv
module keyed_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 16;
  localparam int WIN  = 16;
  localparam int LEAD = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wdog_irq, wdog_rst;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit flagged = 1'b0;

  keyed_watchdog #(.CW(CW), .ULK_WIN(WIN), .IRQ_LEAD(LEAD)) u_keyed_watchdog (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 190000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired: act=%0d cycles exp<190000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] cs_word(bit flg, bit wide, bit pres, bit open, bit done,
                                          bit [1:0] csel, bit en, bit irq, bit upd,
                                          bit wt, bit st);
    logic [31:0] w;
    w = '0;
    w[14] = flg; w[13] = wide; w[12] = pres; w[11] = open; w[10] = done;
    w[9:8] = csel; w[7] = en; w[6] = irq; w[5] = upd; w[1] = wt; w[0] = st;
    return w;
  endfunction

  function automatic bit is_key(logic [31:0] v);
    return (v == 32'hD928_C520) || (v == 32'hB480_A602) ||
           (v[15:0] == 16'hC520) || (v[15:0] == 16'hA602) ||
           (v[15:0] == 16'hD928) || (v[15:0] == 16'hB480);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: act=0x%08h exp=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(bus_rdata === exp, req, bus_rdata, exp);
  endtask

  task automatic unlock32();
    wr(4'h4, 32'hD928_C520);
  endtask

  task automatic measure(input int t, input bit irq, input bit pres,
                         output int irq_idx, output int rst_idx);
    int lim;
    tick = 1'b0;
    unlock32(); wr(4'h8, 32'(t));
    unlock32(); wr(4'h0, cs_word(0, 1, pres, 0, 0, 0, 1, irq, 1, 0, 0));
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'hB480_A602; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    irq_idx = -1; rst_idx = -1;
    lim = 256 * t + LEAD + 4;
    for (int i = 0; i < lim; i++) begin
      if (wdog_irq && irq_idx < 0) irq_idx = i;
      if (wdog_rst && rst_idx < 0) rst_idx = i;
      if (rst_idx >= 0) break;
      @(negedge clk);
    end
    tick = 1'b0;
    flagged = 1'b1;
    unlock32(); wr(4'h0, cs_word(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
  endtask

  initial begin
    int ii, ri, t;
    logic [31:0] v, junk, lim_now;
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(4'h0, 32'h0000_2420, "R1 ctrl reset");
    rd_chk(4'h4, 32'h0, "R1 counter reset");
    rd_chk(4'h8, 32'h0000_FFFF, "R1 limit reset");

    // R4 locked writes and wrong keys ignored
    wr(4'h8, 32'h1234);
    rd_chk(4'h8, 32'h0000_FFFF, "R4 locked limit write");
    for (int k = 0; k < 8; k++) begin
      junk = $urandom;
      if (!is_key(junk)) wr(4'h4, junk);
    end
    wr(4'h0, 32'h0000_0080);
    rd_chk(4'h0, 32'h0000_2420, "R4 locked ctrl write / wrong keys");

    // R2 32-bit unlock
    unlock32();
    rd_chk(4'h0, 32'h0000_2C20, "R2 wide unlock");
    // R5 one config write closes window, R10 applied clears
    wr(4'h8, 32'h40);
    rd_chk(4'h8, 32'h40, "R5 limit accepted");
    rd_chk(4'h0, 32'h0000_2020, "R5 R10 window closed, applied cleared");
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd_chk(4'h0, 32'h0000_2420, "R10 applied after tick");

    // R5 window closes by time
    unlock32();
    repeat (WIN - 1) @(negedge clk);
    rd_chk(4'h0, 32'h0000_2C20, "R5 window still open at last cycle");
    @(negedge clk);
    rd_chk(4'h0, 32'h0000_2420, "R5 window closed by time");
    wr(4'h8, 32'h77);
    rd_chk(4'h8, 32'h40, "R5 write after window ignored");

    // R11 status bits ignored, reserved bits zero
    unlock32();
    wr(4'h0, 32'hFFFF_6E3F);
    rd_chk(4'h0, cs_word(0, 1, 0, 0, 0, 2'b10, 0, 0, 1, 1, 1), "R11 status write ignored");
    @(negedge clk); tick = 1'b1; @(negedge clk); tick = 1'b0;
    rd_chk(4'h0, cs_word(0, 1, 0, 0, 1, 2'b10, 0, 0, 1, 1, 1), "R11 R10 readback");

    // R6 refresh and R7 counting
    unlock32(); wr(4'h8, 32'h8000);
    unlock32(); wr(4'h0, cs_word(0, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0));
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'h4; bus_wdata = 32'hB480_A602; tick = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd_chk(4'h4, 32'h0, "R6 counter zero after refresh");
    repeat (10) @(negedge clk);
    rd_chk(4'h4, 32'd10, "R7 counter advances per tick");
    wr(4'h4, 32'hB480_A602);
    rd_chk(4'h4, 32'h0, "R6 refresh while running");
    tick = 1'b0;
    unlock32(); wr(4'h0, cs_word(0, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    bus_addr = 4'h4; #1; lim_now = bus_rdata;
    tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
    rd_chk(4'h4, lim_now, "R7 disabled counter holds");

    // R2 R4 random limit values
    for (int k = 0; k < 24; k++) begin
      v = $urandom;
      unlock32(); wr(4'h8, v);
      rd_chk(4'h8, {16'h0, v[15:0]}, "R2 random limit write");
      junk = $urandom;
      if (!is_key(junk)) wr(4'h4, junk);
      wr(4'h8, ~v);
      rd_chk(4'h8, {16'h0, v[15:0]}, "R4 random locked write");
    end

    // R7 expiry at limit
    for (int k = 0; k < 6; k++) begin
      t = (k < 2) ? k + 1 : 1 + int'($urandom_range(39));
      measure(t, 1'b0, 1'b0, ii, ri);
      check(ri == t, "R7 expiry tick", 32'(ri), 32'(t));
      check(ii == -1, "R9 irq silent when disabled", 32'(ii), 32'hFFFF_FFFF);
    end
    rd_chk(4'h0, cs_word(1, 1, 0, 0, 0, 0, 0, 0, 1, 0, 0), "R7 flag set");

    // R8 prescaler
    measure(2, 1'b0, 1'b1, ii, ri);
    check(ri == 512, "R8 prescaled expiry", 32'(ri), 32'd512);

    // R9 interrupt before reset
    measure(5, 1'b1, 1'b0, ii, ri);
    check(ii == 5, "R9 irq at expiry", 32'(ii), 32'd5);
    check(ri == 5 + LEAD, "R9 reset after lead", 32'(ri), 32'(5 + LEAD));

    // R3 16-bit unlock
    repeat (LEAD + 2) @(negedge clk);
    unlock32(); wr(4'h0, cs_word(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0));
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    rd_chk(4'h0, cs_word(flagged, 0, 0, 1, 0, 0, 0, 0, 1, 0, 0), "R3 paired unlock");
    wr(4'h8, 32'h0123);
    rd_chk(4'h8, 32'h0123, "R3 limit after paired unlock");
    wr(4'h4, 32'hD928); wr(4'h4, 32'hC520);
    wr(4'h8, 32'h0999);
    rd_chk(4'h8, 32'h0123, "R3 reversed pair rejected");
    wr(4'h4, 32'hC520); wr(4'h4, 32'h1234); wr(4'h4, 32'hD928);
    rd_chk(4'h0, cs_word(flagged, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0), "R3 broken pair rejected");

    // R12 update-allowed cleared
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    wr(4'h0, 32'h0);
    rd_chk(4'h0, cs_word(flagged, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R12 upd cleared");
    wr(4'h4, 32'hC520); wr(4'h4, 32'hD928);
    rd_chk(4'h0, cs_word(flagged, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R12 unlock refused");
    wr(4'h8, 32'h0777);
    rd_chk(4'h8, 32'h0123, "R12 limit frozen");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule